// File: doc/BRIEF.md
# Two-Stage Serial Clock Generator

This block derives the serial bus clock of a card interface from a fast reference clock. The clock period is set by two fields. A pre-divide field gives a base tick every divide/2 reference cycles. A rate field then groups (1 + rate) of those ticks into one half period. The output therefore runs at reference / (divide × (1 + rate)) with a 50 % duty cycle. With a 96 MHz reference, that covers the 400 kHz bring-up rate and the 48 MHz top rate. Software chooses the field values and may rewrite them at any time. The block picks up new values only where one output period ends, so the clock never shows a short pulse.

The same block holds a data timeout watchdog. A start pulse latches the timeout field, which counts in units of 2^TO_SHIFT reference cycles (4096 by default), and starts the count. Each activity pulse restarts the count. While stop is high the count holds. When the count runs out, a sticky flag is raised. Alongside the clock, two one-cycle strobes mark its rising and falling edges for the serialiser logic that shares the reference clock.

Top module: `serial_clk_gen`

## Requirements
- R1: While reset is asserted, sck, rise_stb, fall_stb and timeout_flag are all low.
- R2: Let h be the effective half count and N = h × (1 + rate). Each high phase and each low phase of sck lasts N reference cycles, so a full period is 2N. The first rise comes N rising edges after the first edge at which reset is released.
- R3: h is divide shifted right by one, so the least significant bit of divide is ignored. When that shift gives zero (divide of 0 or 1), h is 1, which behaves like a divide of 2.
- R4: divide and rate are sampled only on the edge where sck falls, and on the first edge after reset. A change between those points does not alter the phase in progress. The new values set the length of the low phase that follows the fall.
- R5: rise_stb is high for exactly the one cycle in which sck first reads 1, and fall_stb likewise for 0. The two strobes are never high together, and neither is high when sck has not changed.
- R6: A start pulse latches tmo_units = T and clears the count. timeout_flag reads 1 from the edge T × 2^TO_SHIFT after the start edge onward. A T of 0 behaves like 1 reference cycle.
- R7: While the count runs, an activity pulse restarts it from zero without clearing the flag. The expiry point moves to T × 2^TO_SHIFT edges after the activity edge.
- R8: Each edge at which stop is high (with no start or activity) does not advance the count, so expiry is delayed by one cycle per such edge.
- R9: timeout_flag stays high once set, and activity does not clear it. Only a start pulse clears it, and it reads 0 after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divide | input | DIV_W | Pre-divide field, even values meaningful |
| rate | input | RATE_W | Rate field, period multiplier minus one |
| tmo_units | input | TO_W | Timeout in units of 2^TO_SHIFT cycles |
| start | input | 1 | Begins a timed transfer, clears the flag |
| activity | input | 1 | Restarts a running timeout count |
| stop | input | 1 | Holds the timeout count while high |
| sck | output | 1 | Serial bus clock |
| rise_stb | output | 1 | One-cycle mark of a rising sck edge |
| fall_stb | output | 1 | One-cycle mark of a falling sck edge |
| timeout_flag | output | 1 | Sticky timeout expiry flag |

## Verification
A pre-divide counter that ends one count early or late changes every half period by a multiple of (1 + rate). A bad rate compare changes it by multiples of h. Either error shows at the first edge after reset, within one period, and the sweep over divide and rate separates the two. A configuration loaded at the wrong point shows as a wrong length of the phase in which inputs changed, within the same period. A slip in the timeout counter moves the flag by a fixed number of cycles that is visible at the expected expiry edge, one cycle apart.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;
   localparam int unsigned SCKGEN_DIV_W    = 8;
   localparam int unsigned SCKGEN_RATE_W   = 8;
   localparam int unsigned SCKGEN_TO_W     = 16;
   localparam int unsigned SCKGEN_TO_SHIFT = 12;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } sck_phase_e;
endpackage

// File: rtl/sckgen_prediv.sv
module sckgen_prediv #(
   parameter int unsigned HW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [HW-1:0] half,
   output logic          tick
);
   logic [HW-1:0] cnt;
   logic          at_end;

   assign at_end = (cnt == half - HW'(1));
   assign tick   = en && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (en) begin
         if (at_end) cnt <= '0;
         else        cnt <= cnt + HW'(1);
      end
   end
endmodule

// File: rtl/sckgen_rate.sv
module sckgen_rate #(
   parameter int unsigned RW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [RW-1:0] rate,
   output logic          toggle
);
   logic [RW-1:0] rcnt;
   logic          at_end;

   assign at_end = (rcnt == rate);
   assign toggle = tick && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt <= '0;
      end else if (tick) begin
         if (at_end) rcnt <= '0;
         else        rcnt <= rcnt + RW'(1);
      end
   end
endmodule

// File: rtl/sckgen_timeout.sv
module sckgen_timeout #(
   parameter int unsigned TO_W     = 16,
   parameter int unsigned TO_SHIFT = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TO_W-1:0] units,
   input  logic            start,
   input  logic            activity,
   input  logic            stop,
   output logic            flag
);
   localparam int unsigned CW = TO_W + TO_SHIFT;

   logic [CW-1:0] limit_in;
   logic [CW-1:0] limit_q;
   logic [CW-1:0] cnt;
   logic          armed;
   logic [CW:0]   next_cnt;

   generate
      if (TO_SHIFT == 0) begin : g_unscaled
         assign limit_in = units;
      end else begin : g_scaled
         assign limit_in = {units, {TO_SHIFT{1'b0}}};
      end
   endgenerate

   assign next_cnt = {1'b0, cnt} + (CW+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         limit_q <= '0;
         armed   <= 1'b0;
         flag    <= 1'b0;
      end else if (start) begin
         cnt     <= '0;
         limit_q <= limit_in;
         armed   <= 1'b1;
         flag    <= 1'b0;
      end else if (activity && armed) begin
         cnt <= '0;
      end else if (armed && !stop) begin
         if (next_cnt >= {1'b0, limit_q}) begin
            flag  <= 1'b1;
            armed <= 1'b0;
         end else begin
            cnt <= next_cnt[CW-1:0];
         end
      end
   end
endmodule

// File: rtl/serial_clk_gen.sv
module serial_clk_gen
   import sckgen_pkg::*;
#(
   parameter int unsigned DIV_W    = SCKGEN_DIV_W,
   parameter int unsigned RATE_W   = SCKGEN_RATE_W,
   parameter int unsigned TO_W     = SCKGEN_TO_W,
   parameter int unsigned TO_SHIFT = SCKGEN_TO_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  divide,
   input  logic [RATE_W-1:0] rate,
   input  logic [TO_W-1:0]   tmo_units,
   input  logic              start,
   input  logic              activity,
   input  logic              stop,
   output logic              sck,
   output logic              rise_stb,
   output logic              fall_stb,
   output logic              timeout_flag
);
   localparam int unsigned HW = DIV_W - 1;

   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("serial_clk_gen: DIV_W must be at least 2");
      end
      if (RATE_W < 1) begin : g_bad_rate
         $error("serial_clk_gen: RATE_W must be at least 1");
      end
      if (TO_W + TO_SHIFT > 48) begin : g_bad_to
         $error("serial_clk_gen: timeout counter wider than 48 bits");
      end
   endgenerate

   logic [HW-1:0]     half_in;
   logic [HW-1:0]     cur_half;
   logic [RATE_W-1:0] cur_rate;
   logic              fresh;
   logic              tick;
   logic              toggle;
   sck_phase_e        phase;

   // LSB of divide dropped; a zero result saturates to the minimum half count
   assign half_in = ((divide >> 1) == '0) ? HW'(1) : HW'(divide >> 1);

   sckgen_prediv #(.HW(HW)) u_prediv (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (!fresh),
      .half  (cur_half),
      .tick  (tick)
   );

   sckgen_rate #(.RW(RATE_W)) u_rate (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .rate   (cur_rate),
      .toggle (toggle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fresh    <= 1'b1;
         cur_half <= HW'(1);
         cur_rate <= '0;
         phase    <= PH_LOW;
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
      end else begin
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
         if (fresh) begin
            fresh    <= 1'b0;
            cur_half <= half_in;
            cur_rate <= rate;
         end else if (toggle) begin
            if (phase == PH_HIGH) begin
               phase    <= PH_LOW;
               fall_stb <= 1'b1;
               cur_half <= half_in;
               cur_rate <= rate;
            end else begin
               phase    <= PH_HIGH;
               rise_stb <= 1'b1;
            end
         end
      end
   end

   assign sck = (phase == PH_HIGH);

   sckgen_timeout #(.TO_W(TO_W), .TO_SHIFT(TO_SHIFT)) u_timeout (
      .clk      (clk),
      .rst_n    (rst_n),
      .units    (tmo_units),
      .start    (start),
      .activity (activity),
      .stop     (stop),
      .flag     (timeout_flag)
   );
endmodule

// File: rtl/sckgen_checker.sv
module sckgen_checker (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic activity,
   input logic stop,
   input logic sck,
   input logic rise_stb,
   input logic fall_stb,
   input logic timeout_flag
);
   p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_stb && fall_stb));

   p_rise_marks_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> rise_stb);

   p_fall_marks_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sck) |-> fall_stb);

   p_rise_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |=> !rise_stb);

   p_fall_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |=> !fall_stb);

   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_flag && !start) |=> timeout_flag);

   p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !timeout_flag);

   p_stop_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start && !activity && !timeout_flag) |=> !timeout_flag);
endmodule

bind serial_clk_gen sckgen_checker u_sckgen_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .activity     (activity),
   .stop         (stop),
   .sck          (sck),
   .rise_stb     (rise_stb),
   .fall_stb     (fall_stb),
   .timeout_flag (timeout_flag)
);

// File: tb/tb_serial_clk_gen.sv
`timescale 1ns/1ps
module tb_serial_clk_gen;
   localparam int TO_SHIFT = 12;
   localparam int UNIT     = 1 << TO_SHIFT;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  divide = 8'd6;
   logic [7:0]  rate = 8'd2;
   logic [15:0] tmo_units = 16'd0;
   logic        start = 1'b0;
   logic        activity = 1'b0;
   logic        stop = 1'b0;
   logic        sck, rise_stb, fall_stb, timeout_flag;

   int cyc = 0;
   int n_checks = 0;
   int n_fail = 0;
   logic prev_sck = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   serial_clk_gen #(.TO_SHIFT(TO_SHIFT)) dut (
      .clk(clk), .rst_n(rst_n), .divide(divide), .rate(rate),
      .tmo_units(tmo_units), .start(start), .activity(activity), .stop(stop),
      .sck(sck), .rise_stb(rise_stb), .fall_stb(fall_stb),
      .timeout_flag(timeout_flag)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // R5: strobes must mark exactly the cycles where sck changed
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (sck !== prev_sck) begin
            if (sck) chk(rise_stb && !fall_stb, "R5 rise strobe", {rise_stb, fall_stb}, 2);
            else     chk(fall_stb && !rise_stb, "R5 fall strobe", {rise_stb, fall_stb}, 1);
         end else if (rise_stb || fall_stb) begin
            chk(1'b0, "R5 stray strobe", {rise_stb, fall_stb}, 0);
         end
      end
      prev_sck = sck;
   end

   task automatic wait_rise(output int c);
      do begin @(posedge clk); #1; end while (!rise_stb);
      c = cyc;
   endtask

   task automatic wait_fall(output int c);
      do begin @(posedge clk); #1; end while (!fall_stb);
      c = cyc;
   endtask

   task automatic wait_to(input int t);
      while (cyc < t) begin @(posedge clk); #1; end
   endtask

   task automatic do_start(input int units, output int e);
      @(negedge clk);
      tmo_units = 16'(units);
      start = 1'b1;
      @(posedge clk); #1;
      e = cyc;
      chk(timeout_flag == 1'b0, "R9 start clears flag", timeout_flag, 0);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic pulse_act(output int a);
      @(negedge clk);
      activity = 1'b1;
      @(posedge clk); #1;
      a = cyc;
      @(negedge clk);
      activity = 1'b0;
   endtask

   initial begin
      #1_600_000;
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      int e0, r0, f0, r1, f1, r2, h_old, h_new, e, a;
      repeat (3) @(posedge clk);
      #1;
      chk(!sck && !rise_stb && !fall_stb && !timeout_flag, "R1 reset state",
          {sck, rise_stb, fall_stb, timeout_flag}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      e0 = cyc;
      wait_rise(r0);
      chk(r0 - e0 == 9, "R2 first rise after reset", r0 - e0, 9);
      h_old = 9;

      // sweep divide and rate; changes land mid high phase
      for (int d = 0; d < 10; d++) begin
         for (int r = 0; r < 4; r++) begin
            h_new = (((d / 2) == 0) ? 1 : (d / 2)) * (r + 1);
            @(negedge clk);
            divide = 8'(d);
            rate = 8'(r);
            wait_fall(f0);
            chk(f0 - r0 == h_old, "R4 phase in progress unchanged", f0 - r0, h_old);
            wait_rise(r1);
            chk(r1 - f0 == h_new, "R4 new values from falling edge", r1 - f0, h_new);
            wait_fall(f1);
            chk(f1 - r1 == h_new, (d < 2 || d % 2 == 1) ? "R3 high phase" : "R2 high phase",
                f1 - r1, h_new);
            wait_rise(r2);
            chk(r2 - r1 == 2 * h_new, (d < 2 || d % 2 == 1) ? "R3 full period" : "R2 full period",
                r2 - r1, 2 * h_new);
            r0 = r2;
            h_old = h_new;
         end
      end

      // R6: plain expiry with one unit
      do_start(1, e);
      wait_to(e + UNIT - 1);
      chk(timeout_flag == 1'b0, "R6 before expiry", timeout_flag, 0);
      wait_to(e + UNIT);
      chk(timeout_flag == 1'b1, "R6 at expiry", timeout_flag, 1);

      // R6: three units
      do_start(3, e);
      wait_to(e + 3 * UNIT - 1);
      chk(timeout_flag == 1'b0, "R6 three units before", timeout_flag, 0);
      wait_to(e + 3 * UNIT);
      chk(timeout_flag == 1'b1, "R6 three units at", timeout_flag, 1);

      // R7: activity restarts the count
      do_start(1, e);
      wait_to(e + 1999);
      pulse_act(a);
      wait_to(e + UNIT);
      chk(timeout_flag == 1'b0, "R7 old expiry point passed", timeout_flag, 0);
      wait_to(a + UNIT - 1);
      chk(timeout_flag == 1'b0, "R7 before moved expiry", timeout_flag, 0);
      wait_to(a + UNIT);
      chk(timeout_flag == 1'b1, "R7 at moved expiry", timeout_flag, 1);

      // R9: sticky; activity does not clear
      wait_to(a + UNIT + 100);
      chk(timeout_flag == 1'b1, "R9 flag held", timeout_flag, 1);
      pulse_act(a);
      wait_to(a + 5);
      chk(timeout_flag == 1'b1, "R7 activity leaves flag set", timeout_flag, 1);

      // R6: zero units expire after one cycle
      do_start(0, e);
      wait_to(e + 1);
      chk(timeout_flag == 1'b1, "R6 zero units", timeout_flag, 1);

      // R8: stop held for 100 edges delays expiry by 100
      do_start(1, e);
      wait_to(e + 9);
      @(negedge clk);
      stop = 1'b1;
      repeat (100) @(posedge clk);
      @(negedge clk);
      stop = 1'b0;
      wait_to(e + UNIT + 99);
      chk(timeout_flag == 1'b0, "R8 frozen count", timeout_flag, 0);
      wait_to(e + UNIT + 100);
      chk(timeout_flag == 1'b1, "R8 delayed expiry", timeout_flag, 1);

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule